// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler with Two Divisor Encodings

This block turns the core clock into the timing strobes that a SPI shift engine needs to build its serial clock. An 8-bit prescale field from the controller's configuration sets the serial-clock period in core-clock cycles. A mode input selects how that field is read. The compact encoding offers even divisors from 4 to 30. The wide encoding multiplies a 4-bit linear factor by a power of two, which reaches divisors up to 1920.

Every serial-clock period has two phases. A leading-edge strobe closes the first phase and a trailing-edge strobe closes the second. A toggle strobe pulses on both, so the pin driver can flip the serial clock with it. The shift engine raises a run input for the whole transfer. While run is low the divider stays cleared and silent, so the first edge of every transfer comes a fixed number of cycles after run rises. The prescale field and the mode are assumed stable while run is high.

Top module: `spi_sck_prescaler`

## Requirements
- R1: With `ext_mode_i` = 0 (compact encoding), the code is field bits 4:0 and the divisor is 2 × (code − 16). For example, code 0x12 gives 4, 0x15 gives 10 and 0x1F gives 30. Field bits 7:5 have no effect.
- R2: In compact encoding, any code below 0x12 gives a divisor of 4.
- R3: With `ext_mode_i` = 1 (wide encoding), the linear factor is field bits 3:0. The exponent is a 3-bit value whose bit 0 is field bit 4 and whose bits 2:1 are field bits 7:6. The divisor is factor × 2^exponent, so field 0xDF gives the largest divisor, 1920. Field bit 5 has no effect.
- R4: In wide encoding, a linear factor of 0 counts as 1. A resulting divisor below 2 is raised to 2.
- R5: For a divisor D, the first phase lasts floor(D/2) cycles and the second phase lasts the rest. If cycle 0 is the first cycle after the clock edge that samples `run_i` high, the leading strobe falls in the cycles where (cycle mod D) = floor(D/2) − 1. The trailing strobe falls where (cycle mod D) = D − 1.
- R6: `sck_toggle_o` pulses in exactly the cycles where either edge strobe pulses. The leading and trailing strobes never pulse in the same cycle, and they alternate, starting with a leading strobe.
- R7: While `run_i` is low, no strobe pulses and the divider is cleared. A transfer that starts again after even a single low cycle restarts at cycle 0 of R5.
- R8: While reset is asserted, and in the first cycle after it is released, all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_mode_i | input | 1 | 0 = compact even-divisor encoding, 1 = wide factor/exponent encoding |
| presc_field_i | input | 8 | Prescale field |
| run_i | input | 1 | High for the duration of a transfer |
| sck_toggle_o | output | 1 | One-cycle pulse at every serial-clock edge |
| lead_edge_o | output | 1 | One-cycle pulse at the end of the first phase |
| trail_edge_o | output | 1 | One-cycle pulse at the end of the second phase |

## Verification
The bench checks the exact cycle of every strobe over three full periods for divisors at both ends of each encoding.

- **Odd divisors.** A swapped phase split would put the leading strobe one cycle late.
- **Exponent bits.** A wrong exponent-bit order would turn field 0x47 into a divisor other than 28 and field 0x81 into one other than 16.
- **Ignored bits.** If the bits each encoding must ignore were decoded, fields 0xF3 and 0x25 would give the wrong period.
- **Illegal values.** A zero factor or a short compact code left unclamped would give a divisor of 0 or 1, or a negative one, instead of 2 or 4.
- **Restart.** A transfer is dropped for a single cycle and started again. A divider that resumed its old count instead of clearing would put the first edge at the wrong cycle.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

  // field geometry; bit positions are decoded by the configuration neighbour
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned CODE_W     = 5;   // compact code width
  localparam int unsigned FACTOR_W   = 4;   // wide linear factor width
  localparam int unsigned EXP_W      = 3;   // wide exponent width

  localparam int unsigned CODE_BASE  = 16;  // compact offset
  localparam int unsigned CODE_FLOOR = 4;   // smallest compact divisor
  localparam int unsigned WIDE_FLOOR = 2;   // smallest wide divisor

  localparam int unsigned DIV_MAX = ((1 << FACTOR_W) - 1) << ((1 << EXP_W) - 1);
  localparam int unsigned DIV_W   = $clog2(DIV_MAX + 1);

  typedef logic [DIV_W-1:0] div_t;

  typedef enum logic {
    ENC_COMPACT = 1'b0,
    ENC_WIDE    = 1'b1
  } enc_e;

endpackage

// File: rtl/presc_decode.sv
module presc_decode
  import spi_presc_pkg::*;
(
  input  enc_e               enc_i,
  input  logic [FIELD_W-1:0] field_i,
  output div_t               first_len_o,
  output div_t               second_len_o
);

  logic [CODE_W-1:0]   code;
  logic [FACTOR_W-1:0] factor;
  logic [FACTOR_W-1:0] factor_fix;
  logic [EXP_W-1:0]    expo;
  div_t                code_ext;
  div_t                compact_div;
  div_t                wide_raw;
  div_t                wide_div;
  div_t                div_sel;

  always_comb begin
    // compact: even divisor from an offset code, short codes clamp up
    code     = field_i[CODE_W-1:0];
    code_ext = DIV_W'(code);
    if (code_ext < DIV_W'(CODE_BASE + CODE_FLOOR / 2)) begin
      compact_div = DIV_W'(CODE_FLOOR);
    end else begin
      compact_div = (code_ext << 1) - DIV_W'(2 * CODE_BASE);
    end

    // wide: factor in low bits, exponent gathered from scattered bits
    factor     = field_i[FACTOR_W-1:0];
    factor_fix = (factor == '0) ? FACTOR_W'(1) : factor;
    expo       = {field_i[FIELD_W-1 -: EXP_W-1], field_i[FACTOR_W]};
    wide_raw   = DIV_W'(factor_fix) << expo;
    wide_div   = (wide_raw < DIV_W'(WIDE_FLOOR)) ? DIV_W'(WIDE_FLOOR) : wide_raw;

    div_sel      = (enc_i == ENC_WIDE) ? wide_div : compact_div;
    first_len_o  = div_sel >> 1;
    second_len_o = div_sel - (div_sel >> 1);
  end

endmodule

// File: rtl/presc_phase_gen.sv
module presc_phase_gen
  import spi_presc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  div_t first_len_i,
  input  div_t second_len_i,
  output logic lead_o,
  output logic trail_o
);

  logic active_q, active_d;
  logic phase_q,  phase_d;
  div_t cnt_q,    cnt_d;
  div_t limit;
  logic at_end;
  logic cnt_en;

  always_comb begin
    limit    = phase_q ? second_len_i : first_len_i;
    at_end   = active_q && (cnt_q == limit - DIV_W'(1));
    cnt_en   = active_q && run_i;
    active_d = run_i;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    if (!run_i) begin
      phase_d = 1'b0;
      cnt_d   = '0;
    end else if (cnt_en) begin
      if (at_end) begin
        phase_d = ~phase_q;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
    end
  end

  assign lead_o  = at_end && !phase_q;
  assign trail_o = at_end &&  phase_q;

  // checker state: was the most recent strobe a leading one
  logic last_lead_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_lead_q <= 1'b0;
    else if (!active_q) last_lead_q <= 1'b0;
    else if (lead_o)    last_lead_q <= 1'b1;
    else if (trail_o)   last_lead_q <= 1'b0;
  end

  assert_lead_follows_trail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> !last_lead_q);
  assert_trail_follows_lead_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> last_lead_q);
  assert_count_in_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < limit));
  assert_idle_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!lead_o && !trail_o));
  assert_fixed_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> (cnt_q == '0 && !phase_q));

endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_presc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_mode_i,
  input  logic [FIELD_W-1:0] presc_field_i,
  input  logic               run_i,
  output logic               sck_toggle_o,
  output logic               lead_edge_o,
  output logic               trail_edge_o
);

  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sr_q;
  logic                   rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sr_q <= '0;
    else         rst_sr_q <= {rst_sr_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sr_q[SYNC_STAGES-1];

  enc_e enc;
  div_t first_len;
  div_t second_len;
  logic lead;
  logic trail;

  assign enc = ext_mode_i ? ENC_WIDE : ENC_COMPACT;

  presc_decode u_decode (
    .enc_i        (enc),
    .field_i      (presc_field_i),
    .first_len_o  (first_len),
    .second_len_o (second_len)
  );

  presc_phase_gen u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .run_i        (run_i),
    .first_len_i  (first_len),
    .second_len_i (second_len),
    .lead_o       (lead),
    .trail_o      (trail)
  );

  assign lead_edge_o  = lead;
  assign trail_edge_o = trail;
  assign sck_toggle_o = lead | trail;

  assert_short_code_clamp_R2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (!ext_mode_i && presc_field_i[CODE_W-1:0] < CODE_W'(18))
      |-> (first_len == DIV_W'(2) && second_len == DIV_W'(2)));
  assert_zero_factor_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ext_mode_i && presc_field_i[FACTOR_W-1:0] == '0 && presc_field_i[7:6] == 2'b00
      && !presc_field_i[FACTOR_W]) |-> (first_len == DIV_W'(1) && second_len == DIV_W'(1)));
  assert_divisor_range_R3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ((first_len + second_len) >= DIV_W'(WIDE_FLOOR)
      && (first_len + second_len) <= DIV_W'(DIV_MAX)));
  assert_strobes_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !(lead_edge_o && trail_edge_o));

endmodule

// File: tb/spi_sck_prescaler_tb_top.sv
`timescale 1ns/1ps
module spi_sck_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_mode;
  logic [7:0] field;
  logic       run;
  logic       tog, lead, trail;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  spi_sck_prescaler dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ext_mode_i    (ext_mode),
    .presc_field_i (field),
    .run_i         (run),
    .sck_toggle_o  (tog),
    .lead_edge_o   (lead),
    .trail_edge_o  (trail)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // assumes run was raised before the last edge; cycle 0 is sampled next
  task automatic observe(input int d, input int ncyc, input string req, input string tag);
    int h = d / 2;
    int bad_lead = 0, bad_trail = 0, bad_tog = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #1;
      if (lead  !== (((i % d) == h - 1) ? 1'b1 : 1'b0)) bad_lead++;
      if (trail !== (((i % d) == d - 1) ? 1'b1 : 1'b0)) bad_trail++;
      if (tog   !== ((((i % d) == h - 1) || ((i % d) == d - 1)) ? 1'b1 : 1'b0)) bad_tog++;
    end
    check(req, {tag, " leading strobe cycles (R5)"}, bad_lead, 0);
    check(req, {tag, " trailing strobe cycles (R5)"}, bad_trail, 0);
    check("R6", {tag, " toggle strobe"}, bad_tog, 0);
  endtask

  task automatic run_pattern(input logic mode, input logic [7:0] f, input int d,
                             input string req, input string tag);
    @(negedge clk);
    run = 1'b0; ext_mode = mode; field = f;
    @(negedge clk);
    run = 1'b1;
    observe(d, 3 * d, req, tag);
    @(negedge clk);
    run = 1'b0;
  endtask

  task automatic test_reset();
    int seen = 0;
    rst_n = 1'b0; run = 1'b1; ext_mode = 1'b0; field = 8'h12;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (tog || lead || trail) seen++;
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    if (tog || lead || trail) seen++;
    check("R8", "strobes in reset", seen, 0);
    @(negedge clk); run = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_idle();
    int seen = 0;
    @(negedge clk); run = 1'b0; ext_mode = 1'b0; field = 8'h12;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (tog || lead || trail) seen++;
    end
    check("R7", "strobes while run low", seen, 0);
  endtask

  task automatic test_restart();
    int seen = 0;
    @(negedge clk); run = 1'b0; ext_mode = 1'b0; field = 8'h15;  // divisor 10
    @(negedge clk); run = 1'b1;
    repeat (7) @(posedge clk);            // part way into the second phase
    @(negedge clk); run = 1'b0;
    @(posedge clk); #1;                   // single low cycle
    if (tog || lead || trail) seen++;
    check("R7", "strobe during single low cycle", seen, 0);
    @(negedge clk); run = 1'b1;
    observe(10, 30, "R7", "restart divisor 10");
    @(negedge clk); run = 1'b0;
  endtask

  initial begin
    ext_mode = 1'b0; field = 8'h00; run = 1'b0;
    test_reset();
    test_idle();
    run_pattern(1'b0, 8'h12, 4,    "R1", "compact 0x12");
    run_pattern(1'b0, 8'h15, 10,   "R1", "compact 0x15");
    run_pattern(1'b0, 8'h1F, 30,   "R1", "compact 0x1F");
    run_pattern(1'b0, 8'hF3, 6,    "R1", "compact upper bits ignored");
    run_pattern(1'b0, 8'h00, 4,    "R2", "compact code 0 clamp");
    run_pattern(1'b0, 8'h11, 4,    "R2", "compact code 0x11 clamp");
    run_pattern(1'b1, 8'h13, 6,    "R3", "wide 0x13");
    run_pattern(1'b1, 8'h47, 28,   "R3", "wide 0x47");
    run_pattern(1'b1, 8'h81, 16,   "R3", "wide 0x81");
    run_pattern(1'b1, 8'hC1, 64,   "R3", "wide 0xC1");
    run_pattern(1'b1, 8'h25, 5,    "R3", "wide bit5 ignored, odd");
    run_pattern(1'b1, 8'hDF, 1920, "R3", "wide max 0xDF");
    run_pattern(1'b1, 8'h00, 2,    "R4", "wide zero field");
    run_pattern(1'b1, 8'h01, 2,    "R4", "wide divisor 1 floor");
    run_pattern(1'b1, 8'h10, 2,    "R4", "wide zero factor exp 1");
    run_pattern(1'b1, 8'h03, 3,    "R5", "wide odd divisor 3");
    test_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule